// File: doc/BRIEF.md
# Transmit Status and Interrupt Register

This block holds the host-visible transmit status of an Ethernet-style MAC. The transmitter reports events as single-cycle pulses: a transmission starting, a whole transmit buffer finished, a collision, a successful packet send and the reception of the node's own good packet. It also reports two levels: carrier sense and whether it is actively sending. The block turns these into sticky status flags, keeps a count of consecutive collisions on the current packet, and raises one interrupt line from the flags the host has enabled.

The host uses a simple synchronous register port with a 2-bit address, a write strobe and a combinational read. The host clears the three interrupting flags by writing 1 to them. The host's transmit-start command passes through the block. It is forwarded only while the transmitter is idle and the done flag is clear.

Register map:

| Address | Contents |
|---|---|
| 0 | Status |
| 1 | Interrupt enable |
| 2 | Collision count in bits 7:4 |
| 3 | Reads 0 |

Status bits:

| Bit | Meaning |
|---|---|
| 7 | Done |
| 6 | Live carrier sense |
| 5 | Self-reception |
| 4 | Carrier lost |
| 2 | Collision |
| 1 | Sixteenth collision |
| 3, 0 | Read 0 |

Top module: `tx_stat_irq`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is 0.
- R2: Status bit 7 sets on `buf_done_i`. Bits 7, 2 and 1 clear only when the host writes 1 to them at address 0. Writing 0 leaves them unchanged.
- R3: When a hardware set and a host write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R4: `irq_o` is high exactly when at least one of status bits 7, 2 and 1 is set together with the same bit of the enable register at address 1.
- R5: Status bit 6 equals `crs_i` in the same cycle. Status bits 3 and 0 always read 0.
- R6: Status bit 5 sets on `self_rx_i` and clears on `tx_begin_i`. If both arrive in the same cycle, the set wins.
- R7: Status bit 4 sets when `crs_i` falls while `tx_active_i` is high. It clears on `tx_begin_i`. A fall of `crs_i` while `tx_active_i` is low does not set it.
- R8: Each `tx_col_i` sets status bit 2 and adds 1 to the collision count in bits 7:4 of address 2. `tx_ok_i` returns the count to 0, and takes priority over a collision in the same cycle.
- R9: A collision arriving while the count is 15 is the sixteenth. It sets status bit 1 and returns the count to 0, because the packet is skipped. The count never wraps past 15 in any other way.
- R10: `start_o` equals `start_req_i` when `tx_active_i` is low and status bit 7 is clear. Otherwise it is 0.
- R11: Only bits 7, 2 and 1 of the enable register are stored. Its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational on addr_i |
| tx_begin_i | input | 1 | Transmission start pulse |
| buf_done_i | input | 1 | Active transmit buffer finished |
| tx_ok_i | input | 1 | Packet sent successfully |
| tx_col_i | input | 1 | Collision pulse |
| crs_i | input | 1 | Receiver carrier sense |
| self_rx_i | input | 1 | Own good packet received after sending |
| tx_active_i | input | 1 | Transmitter is sending |
| start_req_i | input | 1 | Host transmit-start command |
| start_o | output | 1 | Accepted transmit start |
| irq_o | output | 1 | Combined interrupt |

## Verification
A wrong sticky bit or a wrong enable bit appears at `irq_o` and at the address-0 read in the cycle after the event. A mis-stepped collision counter shows at address 2 one cycle after the collision. A fault in the counter's wrap point only appears on the sixteenth collision, so the bench runs every count from 1 through 17. A stale done flag shows immediately as a wrongly blocked or wrongly passed `start_o`.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam int DW = 8;
  localparam logic [1:0] A_STAT = 2'd0;
  localparam logic [1:0] A_IEN  = 2'd1;
  localparam logic [1:0] A_CCNT = 2'd2;
  localparam int B_DONE  = 7;
  localparam int B_BUSY  = 6;
  localparam int B_SELF  = 5;
  localparam int B_CLOST = 4;
  localparam int B_COL   = 2;
  localparam int B_C16   = 1;
  localparam logic [DW-1:0] IRQ_MASK = 8'h86;
endpackage

// File: rtl/tsr_col_cnt.sv
module tsr_col_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             col_i,
  input  logic             ok_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             limit_o
);
  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  assign limit_o = col_i && !ok_i && (cnt_q == MAX_CNT);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (ok_i)    cnt_q <= '0;
    else if (col_i)   cnt_q <= (cnt_q == MAX_CNT) ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_i && !ok_i && cnt_q != MAX_CNT) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R8
  AST_CNT_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_i |=> (cnt_q == '0)); // R8
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_i && !ok_i && cnt_q == MAX_CNT) |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/tsr_status.sv
module tsr_status
  import tsr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] set_i,
  input  logic [DW-1:0] clr_i,
  input  logic          tx_begin_i,
  input  logic          self_rx_i,
  input  logic          crs_i,
  input  logic          tx_active_i,
  output logic [DW-1:0] stat_o
);
  logic [DW-1:0] w1c_q;
  logic          self_q, clost_q, crs_q, clost_set;

  // carrier drop seen only while sending
  assign clost_set = tx_active_i && crs_q && !crs_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w1c_q   <= '0;
      self_q  <= 1'b0;
      clost_q <= 1'b0;
      crs_q   <= 1'b0;
    end else begin
      w1c_q   <= (set_i | (w1c_q & ~clr_i)) & IRQ_MASK;
      self_q  <= self_rx_i | (self_q & ~tx_begin_i);
      clost_q <= clost_set | (clost_q & ~tx_begin_i);
      crs_q   <= crs_i;
    end
  end

  always_comb begin
    stat_o          = w1c_q;
    stat_o[B_BUSY]  = crs_i;
    stat_o[B_SELF]  = self_q;
    stat_o[B_CLOST] = clost_q;
  end

  AST_W0_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w1c_q[B_DONE] && !clr_i[B_DONE]) |=> w1c_q[B_DONE]); // R2
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[B_DONE] |=> w1c_q[B_DONE]); // R3
  AST_SELF_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_begin_i && !self_rx_i) |=> !self_q); // R6
  AST_CLOST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_active_i && !clost_q) |=> !clost_q); // R7
endmodule

// File: rtl/tsr_ien.sv
module tsr_ien
  import tsr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] ien_o
);
  logic [DW-1:0] ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ien_q <= '0;
    else if (we_i) ien_q <= wdata_i & IRQ_MASK;
  end

  assign ien_o = ien_q;

  AST_IEN_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q & ~IRQ_MASK) == '0); // R11
endmodule

// File: rtl/tx_stat_irq.sv
module tx_stat_irq
  import tsr_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    addr_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          tx_begin_i,
  input  logic          buf_done_i,
  input  logic          tx_ok_i,
  input  logic          tx_col_i,
  input  logic          crs_i,
  input  logic          self_rx_i,
  input  logic          tx_active_i,
  input  logic          start_req_i,
  output logic          start_o,
  output logic          irq_o
);
  localparam int PAD_W = DW - CNT_W;

  logic [DW-1:0]    set_v, clr_v, stat, ien;
  logic [CNT_W-1:0] cnt;
  logic             limit;

  always_comb begin
    set_v         = '0;
    set_v[B_DONE] = buf_done_i;
    set_v[B_COL]  = tx_col_i;
    set_v[B_C16]  = limit;
  end

  assign clr_v = (wr_en_i && addr_i == A_STAT) ? (wdata_i & IRQ_MASK) : '0;

  tsr_col_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .col_i   (tx_col_i),
    .ok_i    (tx_ok_i),
    .cnt_o   (cnt),
    .limit_o (limit)
  );

  tsr_status u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (set_v),
    .clr_i       (clr_v),
    .tx_begin_i  (tx_begin_i),
    .self_rx_i   (self_rx_i),
    .crs_i       (crs_i),
    .tx_active_i (tx_active_i),
    .stat_o      (stat)
  );

  tsr_ien u_ien (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i && addr_i == A_IEN),
    .wdata_i (wdata_i),
    .ien_o   (ien)
  );

  always_comb begin
    unique case (addr_i)
      A_STAT:  rdata_o = stat;
      A_IEN:   rdata_o = ien;
      A_CCNT:  rdata_o = {cnt, {PAD_W{1'b0}}};
      default: rdata_o = '0;
    endcase
  end

  assign irq_o   = |(stat & ien & IRQ_MASK);
  assign start_o = start_req_i && !tx_active_i && !stat[B_DONE];

  AST_START_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> (!tx_active_i && !stat[B_DONE])); // R10
  AST_IRQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((stat & IRQ_MASK) != '0)); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat[3] == 1'b0) && (stat[0] == 1'b0)); // R5
endmodule

// File: tb/tx_stat_irq_tb.sv
module tx_stat_irq_tb;
  localparam int CLK_P = 10;

  logic       clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic       wr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic tx_begin = 0, buf_done = 0, tx_ok = 0, tx_col = 0, crs = 0;
  logic self_rx = 0, tx_active = 0, start_req = 0, start, irq;
  int   errors = 0, checks = 0;

  always #(CLK_P/2) clk = ~clk;

  tx_stat_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .tx_begin_i(tx_begin), .buf_done_i(buf_done), .tx_ok_i(tx_ok),
    .tx_col_i(tx_col), .crs_i(crs), .self_rx_i(self_rx), .tx_active_i(tx_active),
    .start_req_i(start_req), .start_o(start), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    addr = a;
    #1;
    chk(tag, rdata, exp);
  endtask

  // drive on negedge, settle through one posedge
  task automatic step();
    @(negedge clk);
    wr = 0; buf_done = 0; tx_col = 0; tx_ok = 0; tx_begin = 0; self_rx = 0;
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1;
    step();
  endtask

  task automatic col_n(input int n);
    for (int i = 0; i < n; i++) begin
      tx_col = 1;
      step();
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] en_v, st_v;
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    rd(0, 8'h00, "R1 status");
    rd(1, 8'h00, "R1 enable");
    rd(2, 8'h00, "R1 count");
    chk("R1 irq", {7'd0, irq}, 8'd0);
    rst_n = 1;
    step();

    // R4/R11 sweep enable x status combos
    for (int e = 0; e < 8; e++) begin
      for (int s = 0; s < 8; s++) begin
        en_v = {e[2], 4'b0, e[1], e[0], 1'b0};
        wreg(0, 8'h86);
        tx_ok = 1; step();
        wreg(1, en_v | 8'h79);
        if (s[2]) begin buf_done = 1; step(); end
        if (s[1]) col_n(1);
        if (s[0]) begin col_n(16); tx_ok = 1; step(); end
        st_v = {s[2], 4'b0, s[1] | s[0], s[0], 1'b0};
        rd(1, en_v, "R11 enable mask");
        rd(0, st_v, "R4 status");
        chk("R4 irq", {7'd0, irq}, {7'd0, |(st_v & en_v)});
      end
    end
    wreg(1, 8'h00);
    wreg(0, 8'h86);

    // R2 set, write 0 no effect, write 1 clears
    buf_done = 1; step();
    rd(0, 8'h80, "R2 done set");
    wreg(0, 8'h00);
    rd(0, 8'h80, "R2 write0 keeps");
    wreg(0, 8'h06);
    rd(0, 8'h80, "R2 other mask keeps");
    wreg(0, 8'h80);
    rd(0, 8'h00, "R2 write1 clears");

    // R3 set beats clear
    addr = 0; wdata = 8'h80; wr = 1; buf_done = 1;
    step();
    rd(0, 8'h80, "R3 set wins");
    wreg(0, 8'h80);

    // R10 start gating
    for (int c = 0; c < 4; c++) begin
      if (c[1]) begin buf_done = 1; step(); end
      tx_active = c[0]; start_req = 1;
      #1;
      chk("R10 start", {7'd0, start}, {7'd0, !c[0] && !c[1]});
      start_req = 0; tx_active = 0;
      #1;
      chk("R10 no req", {7'd0, start}, 8'd0);
      wreg(0, 8'h80);
    end

    // R5 live carrier, reserved zero
    crs = 1;
    wreg(0, 8'hFF);
    rd(0, 8'h40, "R5 crs live");
    crs = 0;
    rd(0, 8'h00, "R5 crs drop");

    // R6 self reception
    self_rx = 1; step();
    rd(0, 8'h20, "R6 self set");
    tx_begin = 1; step();
    rd(0, 8'h00, "R6 begin clears");
    self_rx = 1; tx_begin = 1; step();
    rd(0, 8'h20, "R6 set wins");
    tx_begin = 1; step();

    // R7 carrier lost
    crs = 1; step();
    crs = 0; step();
    rd(0, 8'h00, "R7 idle no set");
    tx_active = 1; crs = 1; step();
    crs = 0; step();
    rd(0, 8'h10, "R7 lost set");
    tx_active = 0;
    tx_begin = 1; step();
    rd(0, 8'h00, "R7 begin clears");

    // R8/R9 counter sweep
    for (int n = 1; n <= 17; n++) begin
      col_n(1);
      rd(2, 8'((n % 16) << 4), "R8 count");
      rd(0, {5'b0, 1'b1, (n >= 16), 1'b0}, "R9 status");
    end
    tx_ok = 1; step();
    rd(2, 8'h00, "R8 ok resets");
    col_n(3);
    tx_ok = 1; tx_col = 1; step();
    rd(2, 8'h00, "R8 ok beats col");
    rd(3, 8'h00, "R1 unused addr");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule